// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a contactless-reader style peripheral. An SPI master (mode 0) reaches a 64-entry, 8-bit register space through it. The register space itself is not part of the block. The block presents a plain internal port to that space: an address, a one-cycle write strobe with write data, and a one-cycle read strobe. Read data is returned on the cycle after the read strobe, which suits a block-RAM style register file.

Every chip-select frame starts with a command byte. Bit 7 of the command byte picks the direction, and bits 6:1 carry the register number.

- **Write frames:** every following byte is written to the same register. The address does not advance, so a FIFO data port mapped at that register can take a stream of bytes.
- **Read frames:** every byte the master sends in a data slot is the address of the next read. The data for a given address is shifted out in the slot after the slot that carried that address. The master closes the frame with a 0x00 byte.

SCK, MOSI and chip select are brought into the system clock domain through flop synchronisers. SCK edges are detected in that domain. For this reason each SCK high phase and each SCK low phase must last at least six system clocks.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, spi_miso_oe and spi_miso are 0, and neither reg_wr nor reg_rd is asserted.
- R2: The first complete byte after spi_cs_n falls is the command byte, received MSB first. Its bits 6:1 give the register number, and its bit 0 is ignored.
- R3: When command bit 7 is 0, each later complete byte in the frame gives exactly one reg_wr pulse. The pulse carries that byte on reg_wdata, and the register number stays the one from the command byte.
- R4: When command bit 7 is 1, one reg_rd pulse is issued for the command's register. That register's value is shifted out MSB first on spi_miso during the next byte slot. spi_miso changes after falling SCK edges and is valid at the rising edges.
- R5: In a read frame, each byte received in a data slot (bits 6:1) is the address of one further reg_rd pulse. That register's value is returned in the slot that follows.
- R6: A byte left incomplete when spi_cs_n rises is discarded. It gives no strobe, and the register it would have written keeps its value.
- R7: While spi_cs_n is high, spi_miso_oe is 0 and spi_miso is 0. Within a frame, spi_miso is 0 during the command byte and during every data slot of a write frame.
- R8: A frame aborted part way through, even inside its command byte, leaves no state behind. The next frame decodes its first byte as a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for spi_miso, high while selected |
| reg_addr | output | 6 | Register number on the internal port |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
The bench targets the byte-slot offset of read data. A design that returns data in the same slot as its address, or that fails to refetch on each slot of a burst, shifts out the wrong register or a stale value.

It streams three bytes into one register. A design that increments the address spreads those bytes across neighbouring registers. A design that treats bit 0 of the command as part of the register number writes to the wrong register.

It also aborts frames in the middle of a data byte and in the middle of a command byte. A design that keeps the partial bit count or the previous phase either writes garbage or misreads the next frame's command.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = 6;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WRITE,
    PH_READ
  } phase_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned BYTE_W = spi_reg_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] load_val,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              miso_bit
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sck_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, rx_next;

  assign rise    = sck_s & ~sck_q;
  assign fall    = ~sck_s & sck_q;
  assign rx_next = {rx_sh[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
    end else begin
      sck_q    <= sck_s;
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          rx_sh <= rx_next;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt  <= '0;
            byte_vld <= 1'b1;
            byte_val <= rx_next;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (fall) begin
          if (bit_cnt == '0) tx_sh <= load_val;
          else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_bit = tx_sh[BYTE_W-1];

  // R2: a byte takes many cycles, so completion is a single pulse
  a_r2_byte_pulse: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl #(
  parameter int unsigned BYTE_W = spi_reg_pkg::BYTE_W,
  parameter int unsigned REG_AW = spi_reg_pkg::REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  output logic [BYTE_W-1:0] load_val
);
  import spi_reg_pkg::*;

  localparam int unsigned RD_FLAG = BYTE_W - 1;

  phase_t phase;
  logic   rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
      rd_pend   <= 1'b0;
      load_val  <= '0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_pend <= reg_rd;
      if (rd_pend) load_val <= reg_rdata;
      if (!cs_act) begin
        phase    <= PH_CMD;
        load_val <= '0;
      end else if (byte_vld) begin
        unique case (phase)
          PH_CMD: begin
            reg_addr <= byte_val[REG_AW:1];
            if (byte_val[RD_FLAG]) begin
              phase  <= PH_READ;
              reg_rd <= 1'b1;
            end else begin
              phase    <= PH_WRITE;
              load_val <= '0;
            end
          end
          PH_WRITE: begin
            reg_wr    <= 1'b1;
            reg_wdata <= byte_val;
          end
          PH_READ: begin
            reg_addr <= byte_val[REG_AW:1];
            reg_rd   <= 1'b1;
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  // R3: streamed writes never move the address
  a_r3_wr_addr_steady: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> $stable(reg_addr));
  // R4: the two strobes never coincide
  a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));
  // R5: one read strobe per byte slot
  a_r5_rd_single: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int unsigned BYTE_W      = spi_reg_pkg::BYTE_W,
  parameter int unsigned REG_AW      = spi_reg_pkg::REG_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [2:0]        pins_s;
  logic              cs_act;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_val;
  logic [BYTE_W-1:0] load_val;
  logic              miso_bit;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({spi_cs_n, spi_sck, spi_mosi}),
    .q_out (pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .sck_s    (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .load_val (load_val),
    .byte_vld (byte_vld),
    .byte_val (byte_val),
    .miso_bit (miso_bit)
  );

  spi_frame_ctrl #(.BYTE_W(BYTE_W), .REG_AW(REG_AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .byte_vld  (byte_vld),
    .byte_val  (byte_val),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .load_val  (load_val)
  );

  always_ff @(posedge clk) begin
    if (rst) spi_miso_oe <= 1'b0;
    else     spi_miso_oe <= cs_act;
  end

  assign spi_miso = miso_bit;

  // R7: nothing driven while deselected
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    !spi_miso_oe |-> !spi_miso);
  // R6: strobes only follow a byte completed inside a frame
  a_r6_strobe_in_frame: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |-> $past(cs_act));
endmodule

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic [5:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] mem [64];
  logic [5:0] wlog_a [32];
  logic [7:0] wlog_d [32];
  logic [5:0] rlog_a [32];
  int wcnt, rcnt;

  always #4 clk = ~clk;

  spi_reg_slave uut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  // register file model: one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      wcnt <= 0;
      rcnt <= 0;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wlog_a[wcnt % 32] <= reg_addr;
        wlog_d[wcnt % 32] <= reg_wdata;
        wcnt <= wcnt + 1;
      end
      if (reg_rd) begin
        reg_rdata <= mem[reg_addr];
        rlog_a[rcnt % 32] <= reg_addr;
        rcnt <= rcnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      spi_mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      rx[7-i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic t_reset();
    chk("R1 miso_oe", 32'(spi_miso_oe), 0);
    chk("R1 miso", 32'(spi_miso), 0);
    chk("R1 reg_wr", 32'(reg_wr), 0);
    chk("R1 reg_rd", 32'(reg_rd), 0);
  endtask

  task automatic t_write_stream();
    logic [7:0] rx;
    logic [7:0] dat [3];
    int base;
    dat[0] = 8'hA1; dat[1] = 8'hB2; dat[2] = 8'hC3;
    base = wcnt;
    cs_begin();
    spi_byte(8'h14, rx);                 // write, register 10
    chk("R7 cmd slot miso", 32'(rx), 0);
    for (int k = 0; k < 3; k++) begin
      spi_byte(dat[k], rx);
      chk("R7 write slot miso", 32'(rx), 0);
    end
    cs_end();
    chk("R3 write count", 32'(wcnt - base), 3);
    for (int k = 0; k < 3; k++) begin
      chk("R3 write addr", 32'(wlog_a[(base + k) % 32]), 10);
      chk("R3 write data", 32'(wlog_d[(base + k) % 32]), 32'(dat[k]));
    end
    chk("R7 idle oe", 32'(spi_miso_oe), 0);
    chk("R7 idle miso", 32'(spi_miso), 0);
  endtask

  task automatic t_bit0_ignored();
    logic [7:0] rx;
    int base;
    base = wcnt;
    cs_begin();
    spi_byte(8'h15, rx);                 // bit 0 set, still register 10
    spi_byte(8'h5E, rx);
    cs_end();
    chk("R2 bit0 count", 32'(wcnt - base), 1);
    chk("R2 bit0 addr", 32'(wlog_a[base % 32]), 10);
  endtask

  task automatic t_single_read();
    logic [7:0] rx;
    int base;
    base = rcnt;
    cs_begin();
    spi_byte(8'h8A, rx);                 // read register 5
    chk("R7 read cmd miso", 32'(rx), 0);
    spi_byte(8'h00, rx);
    chk("R4 read data", 32'(rx), 32'(init_val(5)));
    cs_end();
    chk("R4 read addr", 32'(rlog_a[base % 32]), 5);
  endtask

  task automatic t_burst_read();
    logic [7:0] rx;
    int base;
    int adr [4];
    adr[0] = 3; adr[1] = 20; adr[2] = 63; adr[3] = 0;
    base = rcnt;
    cs_begin();
    spi_byte(8'(8'h80 | (adr[0] << 1)), rx);
    for (int k = 1; k < 4; k++) begin
      spi_byte(k == 3 ? 8'h00 : 8'(8'h80 | (adr[k] << 1)), rx);
      chk("R5 burst data", 32'(rx), 32'(init_val(adr[k-1])));
    end
    cs_end();
    chk("R5 read strobes", 32'(rcnt - base), 4);
    for (int k = 0; k < 4; k++)
      chk("R5 burst addr", 32'(rlog_a[(base + k) % 32]), 32'(adr[k]));
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    int base;
    base = wcnt;
    cs_begin();
    spi_byte(8'h14, rx);
    spi_bits(8'hFF, 4, rx);              // partial data byte
    cs_end();
    chk("R6 no write on partial", 32'(wcnt - base), 0);
    cs_begin();
    spi_bits(8'h00, 5, rx);              // partial command byte
    cs_end();
    chk("R6 no write on partial cmd", 32'(wcnt - base), 0);
    cs_begin();
    spi_byte(8'h94, rx);                 // read register 10
    spi_byte(8'h00, rx);
    cs_end();
    chk("R6 register kept", 32'(rx), 32'h5E);
    chk("R8 fresh command decoded", 32'(rlog_a[(rcnt - 2) % 32]), 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_stream();
    t_bit0_ignored();
    t_single_read();
    t_burst_read();
    t_abort();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule